// File: doc/BRIEF.md
# Triple Programmable Interval Timer

This block holds three independent 16-bit down-counters behind an 8-bit register port. Each counter has a 16-bit start-value latch. It counts enabled clock events, which come from the system clock or from its own external clock pin, and only while its active-low gate pin is low. When a counter passes zero it reloads from its latch, toggles its waveform state and raises its timer flag. The waveform pin of a timer follows that toggle state only while the timer's output-enable bit is set. Any flag whose interrupt-enable bit is set pulls the active-low interrupt pin low.

Values wider than the bus go through one shared high-byte holding register. Software writes the high byte first, and the following low-byte write moves both bytes into the chosen latch in a single step. A read of a counter's high byte captures its low byte, and the next low-byte read returns that captured byte, so a 16-bit value read as two bytes is always consistent. A counter can also run as two cascaded 8-bit stages. The third timer has an optional divide-by-8 stage ahead of its counter.

Top module: `tri_interval_timer`

## Requirements
- R1: After `rst` the waveform pins are low, `irq_n` is high, the status read returns 0x00 and all counters are held (the hold bit in control word 1 is set).
- R2: A write to an even address 2/4/6 loads the shared high-byte buffer. A write to the odd address above it (3/5/7, timers 1/2/3) stores {buffer, data} into that timer's latch. A read of an even address returns the counter's high byte and captures its low byte, which the next odd-address read returns. All read data appears on `bus_rdata` one cycle after the read strobe. While timers are held, each counter equals its latch.
- R3: Address 1 writes control word 2. Address 0 writes control word 1 when bit 0 of control word 2 is 1, and control word 3 when that bit is 0.
- R4: In 16-bit mode with latch N, the first toggle of the waveform comes N+1 counting events after release, and every later toggle comes N+1 events after the one before.
- R5: With control bit 2 set (two 8-bit stages), the low byte reloads from the latch's low byte each time it wraps, and the high byte steps once per wrap. The toggle period is (H+1)*(L+1) events for latch {H,L}.
- R6: Bit 0 of control word 3 makes timer 3 count one event in every 8 system clocks, so its period is 8*(N+1) cycles.
- R7: With control bit 1 = 0 a timer counts rising edges of its `ext_clk` pin after a two-stage synchroniser (bit 1 = 1 selects the system clock). While its `gate_n` is high, no event is counted.
- R8: While control bit 7 (output enable) is 0, the timer's `wave_out` pin stays low.
- R9: Each timeout sets that timer's flag. A status read (address 1) returns the flags of timers 1..3 in bits 0..2, their OR in bit 7 and zeros in bits 6:3.
- R10: `irq_n` is low exactly when some flag is set whose control bit 6 (interrupt enable) is 1.
- R11: A flag clears only when the status has been read while the flag was set, followed by a high-byte read of that timer's counter. A counter read with no prior status read leaves the flag set.
- R12: While bit 0 of control word 1 is set, every counter reloads from its latch, all flags and waveform states clear, and the divide-by-8 stage restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| ext_clk | input | 3 | External clock per timer |
| gate_n | input | 3 | Active-low count enable per timer |
| wave_out | output | 3 | Waveform output per timer |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Read data is due one edge after the read strobe, and a write to the hold bit takes effect on the edge after the write. A counter released at edge E0 therefore toggles at edge E0+N+1 on the system clock and at E0+8(N+1) with the divide-by-8 stage. An external clock edge reaches the counter three edges after the pin rises. The bench drives and samples one nanosecond after each rising edge, counts edges from the releasing write, and leaves several idle cycles after each external pulse before it compares the waveform.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Control word fields kept in hardware (bits 5:3 of the written byte are dropped)
  typedef struct packed {
    logic oe;      // byte bit 7: waveform output enable
    logic ie;      // byte bit 6: interrupt enable
    logic dual;    // byte bit 2: two cascaded 8-bit stages
    logic int_clk; // byte bit 1: 1 = system clock, 0 = external pin
    logic spec;    // byte bit 0: CR1 hold / CR2 select / CR3 prescale
  } ctrl_t;

  localparam logic [2:0] ADDR_CR13 = 3'd0;
  localparam logic [2:0] ADDR_CR2  = 3'd1;
endpackage

// File: rtl/tmr_tick.sv
module tmr_tick #(
  parameter int SYNC_N    = 2,
  parameter int PRESC_W   = 3,
  parameter bit HAS_PRESC = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic ext_clk,
  input  logic gate_n,
  input  logic int_clk,
  input  logic use_presc,
  output logic tick
);
  logic [SYNC_N:0]   clk_sh;
  logic [SYNC_N-1:0] gate_sh;
  logic              base;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_sh  <= '0;
      gate_sh <= '1;
    end else begin
      clk_sh  <= {clk_sh[SYNC_N-1:0], ext_clk};
      gate_sh <= {gate_sh[SYNC_N-2:0], gate_n};
    end
  end

  assign base = ~gate_sh[SYNC_N-1] &
                (int_clk | (clk_sh[SYNC_N-1] & ~clk_sh[SYNC_N]));

  generate
    if (HAS_PRESC) begin : g_presc
      logic [PRESC_W-1:0] presc;
      always_ff @(posedge clk) begin
        if (rst || hold)             presc <= '0;
        else if (base && use_presc)  presc <= presc + 1'b1;
      end
      assign tick = base & (~use_presc | (&presc));
    end else begin : g_plain
      logic unused_in;
      assign unused_in = hold ^ use_presc;
      assign tick = base;
    end
  endgenerate
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 2 * BYTE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             tick,
  input  logic             dual,
  input  logic [CNT_W-1:0] latch,
  output logic [CNT_W-1:0] cnt_q,
  output logic             timeout,
  output logic             tgl_q
);
  logic lo_zero, all_zero;

  assign lo_zero  = (cnt_q[BYTE_W-1:0] == '0);
  assign all_zero = (cnt_q == '0);
  assign timeout  = tick & all_zero;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt_q <= latch;
      tgl_q <= 1'b0;
    end else if (tick) begin
      if (all_zero) begin
        cnt_q <= latch;
        tgl_q <= ~tgl_q;
      end else if (dual && lo_zero) begin
        cnt_q <= {cnt_q[CNT_W-1:BYTE_W] - 1'b1, latch[BYTE_W-1:0]};
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int NUM_T  = 3,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 2 * BYTE_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bus_sel,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [BYTE_W-1:0]           bus_wdata,
  input  logic [NUM_T-1:0][CNT_W-1:0] cnt_q,
  input  logic [NUM_T-1:0]            timeout,
  output ctrl_t [NUM_T-1:0]           ctrl,
  output logic [NUM_T-1:0][CNT_W-1:0] latch_q,
  output logic [NUM_T-1:0]            flags,
  output logic [BYTE_W-1:0]           bus_rdata
);
  localparam int SLOT_W = ADDR_W - 1;

  logic              wr_en, rd_en, hold, stat_rd;
  logic [SLOT_W-1:0] slot;
  logic [BYTE_W-1:0] msb_buf, rd_lsb, status;
  logic [NUM_T-1:0]  armed, cnt_rd;
  ctrl_t             cv;

  assign wr_en   = bus_sel & bus_wr;
  assign rd_en   = bus_sel & ~bus_wr;
  assign slot    = bus_addr[ADDR_W-1:1];
  assign hold    = ctrl[0].spec;
  assign stat_rd = rd_en && (bus_addr == ADDR_CR2);
  assign status  = {|flags, {(BYTE_W-1-NUM_T){1'b0}}, flags};
  assign cv      = '{oe: bus_wdata[7], ie: bus_wdata[6], dual: bus_wdata[2],
                     int_clk: bus_wdata[1], spec: bus_wdata[0]};

  always_comb begin
    for (int i = 0; i < NUM_T; i++)
      cnt_rd[i] = rd_en && !bus_addr[0] && (slot == SLOT_W'(i + 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      ctrl[0]   <= '{oe: 1'b0, ie: 1'b0, dual: 1'b0, int_clk: 1'b0, spec: 1'b1};
      latch_q   <= '0;
      msb_buf   <= '0;
      rd_lsb    <= '0;
      bus_rdata <= '0;
      flags     <= '0;
      armed     <= '0;
    end else begin
      if (wr_en) begin
        if (bus_addr == ADDR_CR13) begin
          if (ctrl[1].spec) ctrl[0]       <= cv;
          else              ctrl[NUM_T-1] <= cv;
        end else if (bus_addr == ADDR_CR2) begin
          ctrl[1] <= cv;
        end else if (!bus_addr[0]) begin
          msb_buf <= bus_wdata;
        end else begin
          for (int i = 0; i < NUM_T; i++)
            if (slot == SLOT_W'(i + 1)) latch_q[i] <= {msb_buf, bus_wdata};
        end
      end
      if (rd_en) begin
        if (bus_addr == ADDR_CR13)  bus_rdata <= '0;
        else if (stat_rd)           bus_rdata <= status;
        else if (bus_addr[0])       bus_rdata <= rd_lsb;
        else begin
          for (int i = 0; i < NUM_T; i++)
            if (cnt_rd[i]) begin
              bus_rdata <= cnt_q[i][CNT_W-1:BYTE_W];
              rd_lsb    <= cnt_q[i][BYTE_W-1:0];
            end
        end
      end
      for (int i = 0; i < NUM_T; i++) begin
        if (hold) begin
          flags[i] <= 1'b0;
          armed[i] <= 1'b0;
        end else if (timeout[i]) begin
          flags[i] <= 1'b1;
        end else if (cnt_rd[i] && armed[i]) begin
          flags[i] <= 1'b0;
          armed[i] <= 1'b0;
        end else if (stat_rd) begin
          armed[i] <= flags[i];
        end
      end
    end
  end
endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
  import tmr_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int SYNC_N  = 2,
  parameter int PRESC_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [2:0]        ext_clk,
  input  logic [2:0]        gate_n,
  output logic [2:0]        wave_out,
  output logic              irq_n
);
  localparam int NUM_T  = 3;
  localparam int ADDR_W = 3;
  localparam int CNT_W  = 2 * BYTE_W;

  ctrl_t [NUM_T-1:0]           ctrl;
  logic [NUM_T-1:0][CNT_W-1:0] cnt_v, latch_v;
  logic [NUM_T-1:0]            tick_v, to_v, tgl_v, flags_v, ie_v, dual_v;
  logic                        hold;

  assign hold = ctrl[0].spec;

  tmr_regs #(.NUM_T(NUM_T), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cnt_q(cnt_v), .timeout(to_v), .ctrl(ctrl),
    .latch_q(latch_v), .flags(flags_v), .bus_rdata(bus_rdata)
  );

  generate
    for (genvar g = 0; g < NUM_T; g++) begin : g_tmr
      tmr_tick #(.SYNC_N(SYNC_N), .PRESC_W(PRESC_W), .HAS_PRESC(g == NUM_T - 1)) u_tick (
        .clk(clk), .rst(rst), .hold(hold), .ext_clk(ext_clk[g]), .gate_n(gate_n[g]),
        .int_clk(ctrl[g].int_clk), .use_presc(ctrl[g].spec), .tick(tick_v[g])
      );
      tmr_count #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .hold(hold), .tick(tick_v[g]), .dual(ctrl[g].dual),
        .latch(latch_v[g]), .cnt_q(cnt_v[g]), .timeout(to_v[g]), .tgl_q(tgl_v[g])
      );
      assign ie_v[g]     = ctrl[g].ie;
      assign dual_v[g]   = ctrl[g].dual;
      assign wave_out[g] = tgl_v[g] & ctrl[g].oe;
    end
  endgenerate

  assign irq_n = ~|(flags_v & ie_v);
endmodule

// File: rtl/tri_interval_timer_chk.sv
module tri_interval_timer_chk #(
  parameter int NUM_T  = 3,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 2 * BYTE_W
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        bus_sel,
  input logic                        bus_wr,
  input logic [2:0]                  bus_addr,
  input logic [BYTE_W-1:0]           bus_rdata,
  input logic                        hold,
  input logic [NUM_T-1:0]            ticks,
  input logic [NUM_T-1:0]            timeouts,
  input logic [NUM_T-1:0]            dual,
  input logic [NUM_T-1:0]            flags,
  input logic [NUM_T-1:0][CNT_W-1:0] cnt,
  input logic [NUM_T-1:0][CNT_W-1:0] latch,
  input logic [NUM_T-1:0]            wave_out,
  input logic                        irq_n
);
  // R9: status byte shape
  a_r9_status_shape: assert property (@(posedge clk) disable iff (rst)
    $past(bus_sel && !bus_wr && bus_addr == 3'd1) |->
      (bus_rdata[BYTE_W-1] == (|bus_rdata[NUM_T-1:0])) &&
      (bus_rdata[BYTE_W-2:NUM_T] == '0));

  // R12: hold forces waveforms low and clears flags
  a_r12_hold_low: assert property (@(posedge clk) disable iff (rst)
    hold |=> (wave_out == '0) && (flags == '0));

  // R10: interrupt only with a pending flag
  a_r10_irq_src: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> (flags != '0));

  generate
    for (genvar g = 0; g < NUM_T; g++) begin : g_chk
      // R9: flag rises only after a timeout
      a_r9_flag_src: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[g]) |-> $past(timeouts[g]));
      // R4: reload from latch after timeout
      a_r4_reload: assert property (@(posedge clk) disable iff (rst)
        $past(timeouts[g] && !hold) |-> (cnt[g] == $past(latch[g])));
      // R4: single step in 16-bit mode
      a_r4_step: assert property (@(posedge clk) disable iff (rst)
        $past(ticks[g] && !hold && !dual[g] && (cnt[g] != '0)) |->
          (cnt[g] == $past(cnt[g]) - 1'b1));
    end
  endgenerate
endmodule

bind tri_interval_timer tri_interval_timer_chk #(.NUM_T(3), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .hold(hold), .ticks(tick_v), .timeouts(to_v), .dual(dual_v),
  .flags(flags_v), .cnt(cnt_v), .latch(latch_v), .wave_out(wave_out), .irq_n(irq_n)
);

// File: tb/tri_interval_timer_bench.sv
`timescale 1ns/1ps
module tri_interval_timer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [2:0] ext_clk = '0, gate_n = '0;
  logic [2:0] wave_out;
  logic       irq_n;
  int total = 0, bad = 0;
  bit done = 1'b0;

  tri_interval_timer u_tri_interval_timer (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk(ext_clk), .gate_n(gate_n),
    .wave_out(wave_out), .irq_n(irq_n)
  );

  always #2 clk = ~clk;

  function automatic int per16(input int n);            return n + 1;             endfunction
  function automatic int per_dual(input int h, input int l); return (h + 1) * (l + 1); endfunction
  function automatic int per_pre(input int n);          return 8 * (n + 1);       endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic set_latch(input int t, input logic [15:0] v);
    wr(3'(2 * (t + 1)), v[15:8]);
    wr(3'(2 * (t + 1) + 1), v[7:0]);
  endtask

  task automatic wait_tgl(input int t, input int maxc, output int n);
    logic p;
    p = wave_out[t];
    n = 0;
    while (n < maxc) begin
      @(posedge clk); #1;
      n++;
      if (wave_out[t] != p) break;
    end
  endtask

  task automatic pulse(input int t);
    ext_clk[t] = 1'b1; idle(2);
    ext_clk[t] = 1'b0; idle(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2;
    int m, n, h, l;
    void'($urandom(32'd4711));
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    idle(2);

    // R1 reset state
    chk("R1 wave_out", int'(wave_out), 0);
    chk("R1 irq_n", int'(irq_n), 1);
    rd(3'd1, d); chk("R1 status", int'(d), 0);

    // R4 16-bit continuous mode on timer 1
    wr(3'd1, 8'h01);
    for (int k = 0; k < 5; k++) begin
      n = $urandom_range(0, 30);
      wr(3'd0, 8'h83);
      set_latch(0, 16'(n));
      wr(3'd0, 8'h82);
      wait_tgl(0, 200, m); chk("R4 first toggle", m, per16(n));
      wait_tgl(0, 200, m); chk("R4 next toggle", m, per16(n));
    end
    wr(3'd0, 8'h83);

    // R2 latch write through buffer, coherent counter read while held
    for (int k = 0; k < 3; k++) begin
      logic [15:0] v;
      v = 16'($urandom);
      set_latch(1, v);
      idle(1);
      rd(3'd4, d); rd(3'd5, d2);
      chk("R2 read msb", int'(d), int'(v[15:8]));
      chk("R2 read lsb", int'(d2), int'(v[7:0]));
    end

    // R8 output disabled, R9 flag and status, R10 masked, R11 clear order
    wr(3'd0, 8'h03);
    set_latch(0, 16'd40);
    wr(3'd0, 8'h02);
    idle(44);
    chk("R8 wave_out low", int'(wave_out[0]), 0);
    chk("R10 masked irq_n", int'(irq_n), 1);
    rd(3'd2, d);
    rd(3'd1, d); chk("R9 R11 status after plain counter read", int'(d), 8'h81);
    rd(3'd2, d);
    rd(3'd1, d); chk("R11 status after clear sequence", int'(d), 0);

    // R10 enabled interrupt, R12 hold clears
    wr(3'd0, 8'hC3);
    set_latch(0, 16'd5);
    wr(3'd0, 8'hC2);
    idle(5);
    chk("R10 irq_n before timeout", int'(irq_n), 1);
    idle(1);
    chk("R10 irq_n at timeout", int'(irq_n), 0);
    chk("R4 wave toggled at timeout", int'(wave_out[0]), 1);
    wr(3'd0, 8'hC3);
    idle(1);
    chk("R12 irq_n released", int'(irq_n), 1);
    chk("R12 wave low", int'(wave_out[0]), 0);
    rd(3'd1, d); chk("R12 flags cleared", int'(d), 0);

    // R5 dual 8-bit mode on timer 2
    wr(3'd0, 8'h01);
    wr(3'd1, 8'h87);
    for (int k = 0; k < 3; k++) begin
      h = $urandom_range(0, 5);
      l = $urandom_range(0, 6);
      wr(3'd0, 8'h01);
      set_latch(1, {8'(h), 8'(l)});
      wr(3'd0, 8'h00);
      wait_tgl(1, 400, m); chk("R5 first period", m, per_dual(h, l));
      wait_tgl(1, 400, m); chk("R5 next period", m, per_dual(h, l));
    end
    wr(3'd0, 8'h01);

    // R3 shared address, R6 prescaler on timer 3
    for (int k = 0; k < 2; k++) begin
      n = $urandom_range(0, 6);
      wr(3'd1, 8'h01);
      wr(3'd0, 8'h01);
      wr(3'd1, 8'h00);
      wr(3'd0, 8'h83);
      set_latch(2, 16'(n));
      wr(3'd1, 8'h01);
      wr(3'd0, 8'h00);
      wait_tgl(2, 400, m); chk("R6 R3 first period", m, per_pre(n));
      wr(3'd1, 8'h00);
      wr(3'd0, 8'h83);
      wait_tgl(2, 400, m); chk("R3 write reached CR3 not CR1", m, per_pre(n) - 2);
    end
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h01);

    // R7 external clock and gate on timer 1
    n = $urandom_range(1, 6);
    wr(3'd0, 8'h81);
    set_latch(0, 16'(n));
    wr(3'd0, 8'h80);
    for (int k = 0; k < n; k++) pulse(0);
    idle(6);
    chk("R7 no toggle after N edges", int'(wave_out[0]), 0);
    pulse(0); idle(6);
    chk("R7 toggle after N+1 edges", int'(wave_out[0]), 1);
    gate_n[0] = 1'b1; idle(4);
    for (int k = 0; k <= n; k++) pulse(0);
    idle(6);
    chk("R7 gate high blocks", int'(wave_out[0]), 1);
    gate_n[0] = 1'b0; idle(4);
    for (int k = 0; k <= n; k++) pulse(0);
    idle(6);
    chk("R7 counts after gate low", int'(wave_out[0]), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule